// File: doc/BRIEF.md
# Multi-Function Accumulator Register

This block is a register A of parameterized width built from identical one-bit cells. Each clock it either keeps its value or loads a new value formed from A and an external operand B. Three one-hot control inputs choose the operation: shift left by one, bitwise exclusive-OR with B, or addition of B.

Every cell holds one full-adder style sum/carry element. All three operations share it. Addition and shift both feed the per-bit carry input: addition takes the ripple carry from the cell below, and shift takes the old bit of A from the cell below. Exclusive-OR forces every carry input to zero, so the sum equals A xor B. The control decode is built once and sent to all cells. The carry out of the top cell during an addition is kept in a separate carry flag.

The block is used as the working register of a small datapath. If more than one control is raised in the same cycle, the block flags the conflict and holds its state.

Top module: `accum_cell_array`

## Requirements
- R1: When rst_n is low at a rising clock edge, acc_q and carry_q become zero at that edge.
- R2: When op_shl, op_xor and op_add are all low, acc_q and carry_q keep their values whatever opnd_b holds.
- R3: With only op_add high, acc_q loads (acc_q + opnd_b) modulo 2^WIDTH and carry_q loads the carry out of the most significant bit.
- R4: With only op_xor high, acc_q loads acc_q xor opnd_b and carry_q keeps its value.
- R5: With only op_shl high, acc_q loads acc_q shifted left by one, with 0 entering bit 0 and the old bit WIDTH-1 dropped. opnd_b has no effect and carry_q keeps its value.
- R6: When two or more controls are high, err_o is 1 in that same cycle and acc_q and carry_q do not change at the edge.
- R7: When at most one control is high, err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_b | input | WIDTH | Operand B |
| op_shl | input | 1 | Select shift left by one |
| op_xor | input | 1 | Select bitwise exclusive-OR with B |
| op_add | input | 1 | Select addition of B |
| acc_q | output | WIDTH | Register A contents |
| carry_q | output | 1 | Carry flag from the most recent addition |
| err_o | output | 1 | Combinational flag, high when more than one control is set |

## Verification
The assertions check every cycle that the hold, shift, exclusive-OR and add updates follow from the previous register value and operand. They also check that a control conflict raises err_o and freezes state, and that reset clears both outputs. Only the bench scenarios show that the shared carry chain ripples over the full width (all-ones plus one). They also show that the carry flag survives the non-add operations across long mixed sequences, and that a reset in the middle of a run clears a nonzero state.

// File: rtl/accum_pkg.sv
// Package: shared control word sent from the single decoder to every bit cell.
// Assumes: the controls are meant to be one-hot; conflicts are resolved by the decoder.
package accum_pkg;

    // Decoded control, computed once and broadcast to all cells
    typedef struct packed {
        logic load;       // register A takes the cell outputs
        logic chain_add;  // carry input of each cell is the ripple carry
        logic chain_shl;  // carry input of each cell is A of the cell below
        logic gate_ab;    // A and B enter the sum logic (low while shifting)
        logic upd_carry;  // carry flag takes the chain carry out
        logic conflict;   // more than one control is high
    } acc_ctrl_t;

endpackage

// File: rtl/accum_ctrl_decode.sv
// Module: accum_ctrl_decode
// Turns the three operation selects into one control word that all cells share.
// Assumes: nothing about the inputs; any pattern with two or more selects set
// is reported as a conflict and suppresses the load.
module accum_ctrl_decode
    import accum_pkg::*;
(
    input  logic      sel_shl,
    input  logic      sel_xor,
    input  logic      sel_add,
    output acc_ctrl_t ctrl
);

    logic [1:0] n_sel;
    logic       any_sel;
    logic       multi;

    // Count the active selects and detect a conflict
    always_comb begin
        n_sel   = 2'(sel_shl) + 2'(sel_xor) + 2'(sel_add);
        any_sel = sel_shl | sel_xor | sel_add;
        multi   = (n_sel > 2'd1);
    end

    // Build the shared control word
    always_comb begin
        ctrl.conflict  = multi;
        ctrl.load      = any_sel & ~multi;
        ctrl.chain_add = sel_add & ~multi;
        ctrl.chain_shl = sel_shl & ~multi;
        ctrl.gate_ab   = ~sel_shl;
        ctrl.upd_carry = sel_add & ~multi;
    end

endmodule

// File: rtl/accum_bit_cell.sv
// Module: accum_bit_cell
// One bit of register A's next-state logic: a gated full adder whose carry input
// is steered by the shared control word.
//   add : cin = ripple carry,  sum = a ^ b ^ cin
//   xor : cin = 0,             sum = a ^ b
//   shl : a, b gated off, cin = A of cell below, sum = that bit
// Assumes: bit 0 is given zero for both neighbour inputs.
module accum_bit_cell
    import accum_pkg::*;
(
    input  acc_ctrl_t ctrl,
    input  logic      a_bit,
    input  logic      b_bit,
    input  logic      a_below,
    input  logic      c_below,
    output logic      sum_bit,
    output logic      c_out
);

    logic cin;
    logic a_g;
    logic b_g;
    logic prop;

    // Pick the carry input of this cell for the active operation
    always_comb begin
        cin = (ctrl.chain_add & c_below) | (ctrl.chain_shl & a_below);
    end

    // Gated full adder shared by all three operations
    always_comb begin
        a_g     = a_bit & ctrl.gate_ab;
        b_g     = b_bit & ctrl.gate_ab;
        prop    = a_g ^ b_g;
        sum_bit = prop ^ cin;
        c_out   = (a_g & b_g) | (prop & cin);
    end

endmodule

// File: rtl/accum_state_reg.sv
// Module: accum_state_reg
// Holds register A and the carry flag. Synchronous active-low reset.
// Assumes: load and upd_carry are never high during a conflict (decoder ensures).
module accum_state_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             upd_carry,
    input  logic [WIDTH-1:0] d_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] q_out,
    output logic             c_q
);

    // Update register A on a valid load, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_out <= '0;
        else if (load)
            q_out <= d_in;
    end

    // Update the carry flag only on additions, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            c_q <= 1'b0;
        else if (upd_carry)
            c_q <= c_in;
    end

endmodule

// File: rtl/accum_cell_array.sv
// Module: accum_cell_array (top)
// Register A of WIDTH identical cells with one shared decode and one carry chain
// used by both add and shift. Flags conflicting selects on err_o.
// Assumes: a synchronous active-low reset; err_o is combinational from the selects.
module accum_cell_array
    import accum_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             op_shl,
    input  logic             op_xor,
    input  logic             op_add,
    output logic [WIDTH-1:0] acc_q,
    output logic             carry_q,
    output logic             err_o
);

    localparam int MSB = WIDTH - 1;

    acc_ctrl_t        ctrl;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] next_a;
    logic [WIDTH-1:0] a_nb;

    accum_ctrl_decode u_dec (
        .sel_shl (op_shl),
        .sel_xor (op_xor),
        .sel_add (op_add),
        .ctrl    (ctrl)
    );

    // Carry enters the bottom of the chain as zero
    always_comb begin
        chain[0] = 1'b0;
    end

    // Replicate the bit cell and wire neighbour links
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i == 0) begin : g_bottom
            assign a_nb[i] = 1'b0;
        end else begin : g_upper
            assign a_nb[i] = acc_q[i-1];
        end

        accum_bit_cell u_cell (
            .ctrl    (ctrl),
            .a_bit   (acc_q[i]),
            .b_bit   (opnd_b[i]),
            .a_below (a_nb[i]),
            .c_below (chain[i]),
            .sum_bit (next_a[i]),
            .c_out   (chain[i+1])
        );
    end

    accum_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctrl.load),
        .upd_carry (ctrl.upd_carry),
        .d_in      (next_a),
        .c_in      (chain[MSB+1]),
        .q_out     (acc_q),
        .c_q       (carry_q)
    );

    // Conflict flag straight from the shared decode
    always_comb begin
        err_o = ctrl.conflict;
    end

endmodule

// File: rtl/accum_checker.sv
// Module: accum_checker
// Property checks on the ports of accum_cell_array, bound to every instance.
// Assumes: rst_n is driven low from time zero by the environment.
module accum_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opnd_b,
    input logic             op_shl,
    input logic             op_xor,
    input logic             op_add,
    input logic [WIDTH-1:0] acc_q,
    input logic             carry_q,
    input logic             err_o
);

    logic [2:0] sels;
    assign sels = {op_shl, op_xor, op_add};

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0) && !carry_q);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sels == 3'b000) |=> $stable(acc_q) && $stable(carry_q));

    assert_add_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sels == 3'b001) |=>
            ({carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(opnd_b)})));

    assert_xor_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sels == 3'b010) |=>
            (acc_q == ($past(acc_q) ^ $past(opnd_b))) && $stable(carry_q));

    assert_shift_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sels == 3'b100) |=>
            (acc_q == {$past(acc_q[WIDTH-2:0]), 1'b0}) && $stable(carry_q));

    assert_conflict_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sels) > 1) |-> err_o);

    assert_conflict_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sels) > 1) |=> $stable(acc_q) && $stable(carry_q));

    assert_no_false_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sels) |-> !err_o);

endmodule

bind accum_cell_array accum_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .opnd_b  (opnd_b),
    .op_shl  (op_shl),
    .op_xor  (op_xor),
    .op_add  (op_add),
    .acc_q   (acc_q),
    .carry_q (carry_q),
    .err_o   (err_o)
);

// File: tb/sim_accum_cell_array.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes the expected state for every cycle and
// queues it; the monitor compares the design after each rising edge.
module sim_accum_cell_array;

    localparam int W = 16;

    typedef struct {
        logic [W-1:0] acc;
        logic         cy;
        logic         err;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opnd_b = '0;
    logic         op_shl = 1'b0;
    logic         op_xor = 1'b0;
    logic         op_add = 1'b0;
    logic [W-1:0] acc_q;
    logic         carry_q;
    logic         err_o;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    logic [W-1:0] m_acc = '0;
    logic         m_cy  = 1'b0;

    always #2 clk = ~clk;

    accum_cell_array #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .opnd_b  (opnd_b),
        .op_shl  (op_shl),
        .op_xor  (op_xor),
        .op_add  (op_add),
        .acc_q   (acc_q),
        .carry_q (carry_q),
        .err_o   (err_o)
    );

    // Drive one cycle at the falling edge and queue the expected result
    task automatic step(input logic rs, input logic s, input logic x,
                        input logic a, input logic [W-1:0] b, input string tag);
        exp_t e;
        logic [W:0] sum;
        int   n;
        @(negedge clk);
        rst_n = rs; op_shl = s; op_xor = x; op_add = a; opnd_b = b;
        n = int'(s) + int'(x) + int'(a);
        e.err = (n > 1);
        if (!rs) begin
            m_acc = '0; m_cy = 1'b0;
        end else if (n == 1) begin
            if (a) begin
                sum = {1'b0, m_acc} + {1'b0, b};
                m_acc = sum[W-1:0]; m_cy = sum[W];
            end else if (x) begin
                m_acc = m_acc ^ b;
            end else begin
                m_acc = {m_acc[W-2:0], 1'b0};
            end
        end
        e.acc = m_acc; e.cy = m_cy;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the design with the queued expectation after each edge
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (acc_q !== e.acc || carry_q !== e.cy || err_o !== e.err) begin
                    n_bad++;
                    $display("FAIL %s: acc=%h cy=%b err=%b expected acc=%h cy=%b err=%b",
                             t, acc_q, carry_q, err_o, e.acc, e.cy, e.err);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: acc=%h expected completion", acc_q);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus
    initial begin
        logic [W-1:0] lf;
        step(1'b0, 0, 0, 0, 16'h1234, "R1");          // reset
        step(1'b0, 0, 0, 1, 16'h5555, "R1");          // reset overrides add
        step(1'b1, 0, 0, 1, 16'h0001, "R3");          // 0 + 1
        step(1'b1, 0, 0, 1, 16'h0002, "R3");          // 1 + 2 = 3
        step(1'b1, 0, 0, 0, 16'hFFFF, "R2");          // idle, B ignored
        step(1'b1, 0, 0, 1, 16'hFFFC, "R3");          // 3 + FFFC = FFFF
        step(1'b1, 0, 0, 1, 16'h0001, "R3");          // full ripple: 0, carry 1
        step(1'b1, 0, 1, 0, 16'h8001, "R4");          // xor, carry held at 1
        step(1'b1, 0, 0, 0, 16'h0000, "R2");          // idle
        step(1'b1, 1, 0, 0, 16'hFFFF, "R5");          // 8001 -> 0002, B ignored
        step(1'b1, 1, 0, 0, 16'h0000, "R5");          // 0002 -> 0004
        step(1'b1, 1, 1, 0, 16'h1111, "R6");          // shl+xor conflict
        step(1'b1, 1, 0, 1, 16'h1111, "R6");          // shl+add conflict
        step(1'b1, 0, 1, 1, 16'h1111, "R6");          // xor+add conflict
        step(1'b1, 1, 1, 1, 16'h1111, "R6");          // all three
        step(1'b1, 0, 1, 0, 16'hC000, "R7");          // single after conflict
        step(1'b1, 1, 0, 0, 16'h0000, "R5");          // MSB dropped
        lf = 16'hACE1;
        for (int k = 0; k < 60; k++) begin
            lf = {lf[W-2:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (k % 5)
                0: step(1'b1, 0, 0, 1, lf, "R3");
                1: step(1'b1, 0, 1, 0, lf, "R4");
                2: step(1'b1, 1, 0, 0, lf, "R5");
                3: step(1'b1, 0, 0, 0, lf, "R2");
                default: step(1'b1, lf[0], lf[1], lf[2], lf, "R6");
            endcase
        end
        step(1'b1, 0, 0, 1, 16'hFFFF, "R3");
        step(1'b0, 0, 0, 0, 16'h0000, "R1");          // reset mid-run
        step(1'b1, 0, 0, 0, 16'h0000, "R2");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule